// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a single-level data cache placed between a processor pipeline's load/store port and a slower word-wide backing memory. It holds a parameterised number of one-word lines (256 by default). Each line keeps a valid bit, a tag and one 32-bit data word. A load that finds its word returns it in the same cycle. A load that misses raises the stall output, fetches the word from memory, installs it in the line its index selects, and hands it to the processor in the cycle the stall drops.

Stores are always sent on to memory. The memory write starts in the same cycle as the tag check, and the processor is held until memory acknowledges it, so at most one memory transaction is outstanding at any time. A store that hits updates the cached word. A store that misses takes no line and instead clears the valid bit of the line at its index.

The processor must hold its request steady while stalled and treats the request as finished in the first cycle with the stall low. Memory sees a level request with address, write flag and write data. These stay stable until it answers with a one-cycle acknowledge, which carries the read word for loads.

Top module: `dm_wt_cache`

## Requirements
- R1: An address splits into a byte offset in bits [1:0], a line index in bits [9:2] and a tag in bits [31:10]. The offset bits take no part in hit detection, and the memory address always has bits [1:0] at zero.
- R2: A load whose line is valid and whose tag matches completes in its first cycle, with stall low, no memory request, and the cached word on the read-data output.
- R3: A load that misses raises stall and a memory read request (write flag low) to its word address in its first cycle.
- R4: When memory acknowledges a load, stall is low in that same cycle and the read-data output equals the memory's returned word. The line is then valid with the new tag and word, so the next load of that word hits.
- R5: A store raises a memory write request carrying its word address and data in its first cycle, whether it hits or misses, and stall stays high until memory acknowledges it.
- R6: A store that hits replaces the cached word, so a later load of that address hits and returns the stored data.
- R7: A store that misses allocates no line and clears the valid bit of the line at its index. A later load of the word previously held there misses, and so does a load of the stored address.
- R8: Two addresses with the same index and different tags share one line, and installing one evicts the other.
- R9: Reset clears every valid bit, so the first load of any address after reset misses.
- R10: While a memory request is waiting for acknowledge, the request stays high and its address, write flag and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access valid |
| cpu_we | input | 1 | Access is a store |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data |
| cpu_stall | output | 1 | Hold the pipeline; the access is not finished |
| mem_req | output | 1 | Memory transaction request, held until acknowledge |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |

## Verification
Directed sequences run on one index. A load after reset, its repeat, and a repeat with different offset bits separate a miss, a hit and offset-blind matching. Loads of a second tag on the same index and back show eviction. A store to a cached word followed by a load shows the write-hit update. A store to a foreign tag followed by loads of both addresses shows invalidation without allocation. Seeded random loads and stores then draw from a few tags and indices, so hits, conflicts and invalidations interleave. The memory latency varies from one to four cycles, which exposes any stall release or data hand-off that is tied to a fixed timing.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 32;
    localparam int OFFSET_W  = 2;
    localparam int DEF_LINES = 256;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } ctl_state_t;

    typedef enum logic [1:0] {
        LOP_NONE,
        LOP_FILL,
        LOP_UPDATE,
        LOP_CLEAR
    } line_op_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } mem_txn_t;

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};
    endfunction

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split
    import dmc_pkg::*;
#(
    parameter int  NUM_LINES = DEF_LINES,
    localparam int INDEX_W   = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - INDEX_W - OFFSET_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [INDEX_W-1:0] index,
    output logic [TAG_W-1:0]   tag
);
    logic unused_offset;

    assign index         = addr[OFFSET_W +: INDEX_W];
    assign tag           = addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^addr[OFFSET_W-1:0];
endmodule

// File: rtl/cache_line_store.sv
module cache_line_store
    import dmc_pkg::*;
#(
    parameter int  NUM_LINES = DEF_LINES,
    localparam int INDEX_W   = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - INDEX_W - OFFSET_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] lk_index,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    output logic [WORD_W-1:0]  lk_data,
    input  line_op_t           op,
    input  logic [INDEX_W-1:0] op_index,
    input  logic [TAG_W-1:0]   op_tag,
    input  logic [WORD_W-1:0]  op_data
);
    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [WORD_W-1:0]    data_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            case (op)
                LOP_FILL:  valid_q[op_index] <= 1'b1;
                LOP_CLEAR: valid_q[op_index] <= 1'b0;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        case (op)
            LOP_FILL: begin
                tag_q[op_index]  <= op_tag;
                data_q[op_index] <= op_data;
            end
            LOP_UPDATE: data_q[op_index] <= op_data;
            default: ;
        endcase
    end

    assign lk_hit  = valid_q[lk_index] && (tag_q[lk_index] == lk_tag);
    assign lk_data = data_q[lk_index];

    // R9: no line is valid in the first cycle after reset
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0));

    // R7: a write-miss invalidation leaves the line empty
    a_r7_clear_line: assert property (@(posedge clk) disable iff (rst)
        (op == LOP_CLEAR) |=> !valid_q[$past(op_index)]);

    // R4: a fill installs tag and word and marks the line valid
    a_r4_fill_line: assert property (@(posedge clk) disable iff (rst)
        (op == LOP_FILL) |=> valid_q[$past(op_index)]
            && (tag_q[$past(op_index)] == $past(op_tag))
            && (data_q[$past(op_index)] == $past(op_data)));
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    input  logic              lookup_hit,
    input  logic [WORD_W-1:0] lookup_data,
    output line_op_t          op,
    output logic [ADDR_W-1:0] op_addr,
    output logic [WORD_W-1:0] op_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    ctl_state_t state_q;
    mem_txn_t   txn_q;
    mem_txn_t   cur_txn;
    logic       idle_access;
    logic       launch;
    logic       done;

    assign idle_access = (state_q == ST_IDLE) && cpu_req;
    assign launch      = idle_access && (cpu_we || !lookup_hit);

    always_comb begin
        if (state_q == ST_IDLE) begin
            cur_txn.we   = cpu_we;
            cur_txn.addr = word_align(cpu_addr);
            cur_txn.data = cpu_wdata;
        end else begin
            cur_txn = txn_q;
        end
    end

    assign mem_req   = launch || (state_q == ST_WAIT);
    assign mem_we    = cur_txn.we;
    assign mem_addr  = cur_txn.addr;
    assign mem_wdata = cur_txn.data;

    assign done      = mem_req && mem_ack;
    assign cpu_stall = mem_req && !mem_ack;
    assign cpu_rdata = (done && !cur_txn.we) ? mem_rdata : lookup_data;

    // line maintenance: store outcome at tag check, fill on read completion
    always_comb begin
        op      = LOP_NONE;
        op_addr = cur_txn.addr;
        op_data = cur_txn.data;
        if (idle_access && cpu_we) begin
            op = lookup_hit ? LOP_UPDATE : LOP_CLEAR;
        end else if (done && !cur_txn.we) begin
            op      = LOP_FILL;
            op_data = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            txn_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (launch && !mem_ack) begin
                    state_q <= ST_WAIT;
                    txn_q   <= cur_txn;
                end
                ST_WAIT: if (mem_ack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a load hit finishes at once without touching memory
    a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cpu_req && !cpu_we && lookup_hit)
            |-> (!cpu_stall && !mem_req));

    // R3: a load miss stalls and issues a read
    a_r3_miss_reads: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cpu_req && !cpu_we && !lookup_hit && !mem_ack)
            |-> (cpu_stall && mem_req && !mem_we));

    // R5: every store is sent to memory during its tag check
    a_r5_store_launch: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cpu_req && cpu_we)
            |-> (mem_req && mem_we && (mem_wdata == cpu_wdata)));

    // R4: read completion releases the stall and forwards memory data
    a_r4_release_data: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && mem_ack && !mem_we)
            |-> (!cpu_stall && (cpu_rdata == mem_rdata)));

    // R10: a pending transaction holds still until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
            && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
    import dmc_pkg::*;
#(
    parameter int  NUM_LINES = DEF_LINES,
    localparam int INDEX_W   = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - INDEX_W - OFFSET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    logic [INDEX_W-1:0] lk_index;
    logic [TAG_W-1:0]   lk_tag;
    logic               lk_hit;
    logic [WORD_W-1:0]  lk_data;
    line_op_t           op;
    logic [ADDR_W-1:0]  op_addr;
    logic [WORD_W-1:0]  op_data;
    logic [INDEX_W-1:0] op_index;
    logic [TAG_W-1:0]   op_tag;

    cache_addr_split #(.NUM_LINES(NUM_LINES)) u_lookup_split (
        .addr  (cpu_addr),
        .index (lk_index),
        .tag   (lk_tag)
    );

    cache_addr_split #(.NUM_LINES(NUM_LINES)) u_op_split (
        .addr  (op_addr),
        .index (op_index),
        .tag   (op_tag)
    );

    cache_line_store #(.NUM_LINES(NUM_LINES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .lk_index (lk_index),
        .lk_tag   (lk_tag),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .op       (op),
        .op_index (op_index),
        .op_tag   (op_tag),
        .op_data  (op_data)
    );

    cache_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .cpu_stall   (cpu_stall),
        .lookup_hit  (lk_hit),
        .lookup_data (lk_data),
        .op          (op),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata)
    );
endmodule

// File: tb/tb_dm_wt_cache.sv
`timescale 1ns/100ps
module tb_dm_wt_cache;
    localparam int LINES = 256;
    localparam int IW    = 8;
    localparam int TW    = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [31:0] bmem [logic [31:0]];
    bit          rv [LINES];
    logic [TW-1:0] rt [LINES];
    logic [31:0] rd [LINES];

    always #2.5 clk = ~clk;

    dm_wt_cache dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    function automatic logic [31:0] mem_value(input logic [31:0] a);
        if (bmem.exists(a)) return bmem[a];
        return init_word(a);
    endfunction

    function automatic logic [31:0] mk_addr(input int tg, input int ix, input int off);
        return {tg[TW-1:0], ix[IW-1:0], off[1:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // backing memory responder: latency 1..4 cycles after the request is seen
    initial begin
        int cnt = 0;
        int lat = 1;
        forever begin
            @(posedge clk);
            #1;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req && !rst) begin
                cnt++;
                if (cnt >= lat) begin
                    cnt = 0;
                    lat = 1 + int'($urandom % 4);
                    mem_ack = 1'b1;
                    if (mem_we) bmem[mem_addr] = mem_wdata;
                    else mem_rdata = mem_value(mem_addr);
                end
            end
        end
    end

    // one processor access; reports whether it stalled and the data returned
    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                          output bit missed, output logic [31:0] data);
        logic [IW-1:0] ix = a[IW+1:2];
        logic [TW-1:0] tg = a[31:IW+2];
        logic [31:0]   wa = {a[31:2], 2'b00};
        bit hit = rv[ix] && (rt[ix] == tg);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1.5;
        missed = cpu_stall;
        data   = cpu_rdata;
        if (!we && hit) begin
            chk(!cpu_stall && !mem_req, "R2 hit without stall or request",
                {30'b0, cpu_stall, mem_req}, 32'h0);
            chk(cpu_rdata == rd[ix], "R2 hit data", cpu_rdata, rd[ix]);
        end else begin
            chk(cpu_stall && mem_req && (mem_we == we), we ? "R5 store launch" : "R3 miss launch",
                {29'b0, cpu_stall, mem_req, mem_we}, {29'b0, 2'b11, we});
            chk(mem_addr == wa, "R1 word-aligned memory address", mem_addr, wa);
            if (we) chk(mem_wdata == wd, "R5 store data", mem_wdata, wd);
            while (cpu_stall) begin
                @(negedge clk);
                #1.5;
                if (cpu_stall)
                    chk(mem_req && mem_addr == wa && mem_we == we && (!we || mem_wdata == wd),
                        "R10 request held", mem_addr, wa);
            end
            data = cpu_rdata;
            if (!we) begin
                chk(cpu_rdata == mem_value(wa), "R4 data on release", cpu_rdata, mem_value(wa));
                rv[ix] = 1; rt[ix] = tg; rd[ix] = mem_value(wa);
            end else begin
                chk(mem_value(wa) == wd, "R5 memory written", mem_value(wa), wd);
                if (hit) rd[ix] = wd;
                else rv[ix] = 0;
            end
        end
        @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd150000, 32'd0);
        finish_run();
    end

    initial begin
        bit miss;
        logic [31:0] d;
        logic [31:0] a_addr, b_addr, c_addr;
        void'($urandom(32'd20240611));
        for (int i = 0; i < LINES; i++) rv[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!cpu_stall && !mem_req, "R9 quiet after reset", {30'b0, cpu_stall, mem_req}, 32'h0);

        a_addr = mk_addr(22'h0A5, 8'h3C, 0);
        b_addr = mk_addr(22'h1F0, 8'h3C, 0);
        c_addr = mk_addr(22'h333, 8'h3C, 0);

        access(0, a_addr, 0, miss, d);
        chk(miss, "R9 first load after reset misses", {31'b0, miss}, 32'h1);
        access(0, a_addr, 0, miss, d);
        chk(!miss, "R4 filled line hits", {31'b0, miss}, 32'h0);
        access(0, a_addr | 32'h3, 0, miss, d);
        chk(!miss && d == mem_value(a_addr), "R1 offset ignored", d, mem_value(a_addr));

        access(0, b_addr, 0, miss, d);
        chk(miss, "R8 conflicting tag misses", {31'b0, miss}, 32'h1);
        access(0, a_addr, 0, miss, d);
        chk(miss, "R8 evicted tag misses", {31'b0, miss}, 32'h1);

        access(1, a_addr, 32'hCAFE_0001, miss, d);
        access(0, a_addr, 0, miss, d);
        chk(!miss && d == 32'hCAFE_0001, "R6 write hit updates line", d, 32'hCAFE_0001);

        access(1, c_addr, 32'hBEEF_0002, miss, d);
        access(0, a_addr, 0, miss, d);
        chk(miss, "R7 write miss invalidates line", {31'b0, miss}, 32'h1);
        access(1, c_addr, 32'hBEEF_0003, miss, d);
        access(0, c_addr, 0, miss, d);
        chk(miss && d == 32'hBEEF_0003, "R7 write miss does not allocate", d, 32'hBEEF_0003);

        for (int n = 0; n < 600; n++) begin
            int tg = 16 + int'($urandom % 3);
            int ix = int'($urandom % 4) * 37;
            int off = int'($urandom % 4);
            bit we = ($urandom % 3) == 0;
            access(we, mk_addr(tg, ix, off), $urandom, miss, d);
        end

        @(negedge clk);
        cpu_req = 1'b0;
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule